// File: doc/BRIEF.md
# Retired-Instruction Counter

This block keeps a 64-bit count of retired instructions for a RISC-V style core. Software sees it as two 32-bit control registers, a low word and a high word. The pipeline raises a one-cycle retire strobe for each instruction that completes. The block also takes the machine counter-inhibit register, and one of its bits freezes the count.

A control-register access happens as part of an instruction. It is qualified by that instruction's retire strobe. A read returns the registered value of the selected word in the cycle the instruction retires, so the instruction's own increment is not visible to it. A write replaces the increment that the writing instruction would have applied, but only in the word it targets. A carry out of the old low value still reaches the high word when the low word is written. When the high word is written, the low word still counts.

Top module: `instret_ctr`

## Requirements
- R1: After reset, both words read as zero.
- R2: With counter-inhibit bit 2 clear, the 64-bit count rises by exactly one in each cycle where `retire_i` is high and no write is made. It holds its value in every cycle where `retire_i` is low, however long the gap.
- R3: `csr_rdata_o` shows the low word when `csr_sel_i` is 0 and the high word when it is 1. The value shown is the registered value, before the current cycle's increment.
- R4: A retiring write to the low word (`csr_sel_i` = 0) loads the write data into the low word instead of incrementing it. After writing 0, the next read returns 0 and the read after that returns 1.
- R5: If the low word held all ones when it was written, the carry from incrementing that old value still increments the high word. Repeated all-ones writes to the low word raise the high word by one per write.
- R6: A retiring write to the high word (`csr_sel_i` = 1) loads the write data into the high word and discards any carry arriving from the low word in that cycle. The low word still increments normally.
- R7: A count of all ones in both words wraps to zero in both words on the next counted retirement.
- R8: While bit 2 of `countinhibit_i` is set, retirements do not change the count, but writes to either word still take effect. After writing 0, two reads both return 0.
- R9: Bits of `countinhibit_i` other than bit 2 have no effect on counting. Once bit 2 is cleared, counting resumes from the next retirement.
- R10: With `retire_i` low, `csr_we_i` has no effect on either word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One-cycle pulse per retired instruction |
| countinhibit_i | input | 32 | Counter-inhibit register value; bit 2 freezes this counter |
| csr_sel_i | input | 1 | Word select: 0 low, 1 high |
| csr_we_i | input | 1 | Write enable, qualified by retire_i |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Registered value of the selected word |

## Verification
The hardest case to reach is a low-word write made while the old low value is all ones. Only in that case does the carry from the discarded increment have to reach the high word. The stimulus first writes all ones to the low word, then repeats the same write several times, and reads the high word to confirm it rose once per write. A second sequence lines up a high-word write with a pending low carry and then with a full 64-bit wrap. It does this by writing all ones minus one to the low word just before writing the high word.

// File: rtl/instret_pkg.sv
package instret_pkg;
  localparam int unsigned XLEN_DEF  = 32;
  localparam int unsigned CNT_W_DEF = 64;
  localparam int unsigned IR_BIT_DEF = 2;
endpackage

// File: rtl/instret_half.sv
module instret_half #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q + {{(W-1){1'b0}}, inc_i};
    if (we_i) d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/instret_rd_mux.sv
module instret_rd_mux #(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic [N-1:0][W-1:0] words_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_i == SEL_W'(i)) rdata_o = words_i[i];
  end
endmodule

// File: rtl/instret_ctr.sv
module instret_ctr #(
  parameter int unsigned XLEN   = instret_pkg::XLEN_DEF,
  parameter int unsigned CNT_W  = instret_pkg::CNT_W_DEF,
  parameter int unsigned IR_BIT = instret_pkg::IR_BIT_DEF,
  localparam int unsigned NWORD = CNT_W / XLEN,
  localparam int unsigned SEL_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [XLEN-1:0]  countinhibit_i,
  input  logic [SEL_W-1:0] csr_sel_i,
  input  logic             csr_we_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o
);
  logic                       count_en;
  logic                       wr_en;
  logic [NWORD-1:0]           carry_in;
  logic [NWORD-1:0][XLEN-1:0] words;
  logic [CNT_W-1:0]           cnt_q;

  assign count_en    = retire_i & ~countinhibit_i[IR_BIT];
  assign wr_en       = retire_i & csr_we_i;
  assign carry_in[0] = count_en;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    // carry computed from old value, independent of any write to this word
    if (g < NWORD - 1) begin : g_carry
      assign carry_in[g+1] = carry_in[g] & (&words[g]);
    end
    instret_half #(.W(XLEN)) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (carry_in[g]),
      .we_i    (wr_en && (csr_sel_i == SEL_W'(g))),
      .wdata_i (csr_wdata_i),
      .q_o     (words[g])
    );
    assign cnt_q[g*XLEN +: XLEN] = words[g];
  end

  instret_rd_mux #(.W(XLEN), .N(NWORD), .SEL_W(SEL_W)) u_rd_mux (
    .words_i (words),
    .sel_i   (csr_sel_i),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/instret_ctr_chk.sv
module instret_ctr_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IR_BIT = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             retire_i,
  input logic [XLEN-1:0]  countinhibit_i,
  input logic [SEL_W-1:0] csr_sel_i,
  input logic             csr_we_i,
  input logic [XLEN-1:0]  csr_wdata_i,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(CNT_W / XLEN - 1);

  // R2
  no_retire_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(cnt_q));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !countinhibit_i[IR_BIT] && !csr_we_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R8
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && countinhibit_i[IR_BIT] && !csr_we_i) |=> $stable(cnt_q));

  // R4
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && csr_we_i && csr_sel_i == '0) |=> cnt_q[XLEN-1:0] == $past(csr_wdata_i));

  // R6
  hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && csr_we_i && csr_sel_i == TOP_SEL) |=>
      cnt_q[CNT_W-1:CNT_W-XLEN] == $past(csr_wdata_i));

  // R5
  lo_write_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && csr_we_i && csr_sel_i == '0 && !countinhibit_i[IR_BIT] && (&cnt_q[XLEN-1:0]))
      |=> cnt_q[CNT_W-1:XLEN] == $past(cnt_q[CNT_W-1:XLEN]) + 1'b1);
endmodule

bind instret_ctr instret_ctr_chk #(
  .XLEN(XLEN), .CNT_W(CNT_W), .IR_BIT(IR_BIT), .SEL_W(SEL_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .retire_i       (retire_i),
  .countinhibit_i (countinhibit_i),
  .csr_sel_i      (csr_sel_i),
  .csr_we_i       (csr_we_i),
  .csr_wdata_i    (csr_wdata_i),
  .cnt_q          (cnt_q)
);

// File: tb/instret_ctr_tb.sv
`timescale 1ns/1ps
module instret_ctr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_i = 1'b0;
  logic [31:0] countinhibit_i = '0;
  logic [0:0]  csr_sel_i = '0;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  instret_ctr u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .retire_i       (retire_i),
    .countinhibit_i (countinhibit_i),
    .csr_sel_i      (csr_sel_i),
    .csr_we_i       (csr_we_i),
    .csr_wdata_i    (csr_wdata_i),
    .csr_rdata_o    (csr_rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample registered read value just after
  task automatic step(input logic ret, input logic we, input logic sel,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk_i);
    retire_i = ret; csr_we_i = we; csr_sel_i = sel; csr_wdata_i = wd;
    #1 rd = csr_rdata_o;
  endtask

  task automatic wr(input logic sel, input logic [31:0] wd);
    logic [31:0] unused_rd;
    step(1'b1, 1'b1, sel, wd, unused_rd);
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    step(1'b1, 1'b0, sel, 32'h0, v);
  endtask

  task automatic idle(input int n);
    logic [31:0] unused_rd;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 32'h0, unused_rd);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    step(1'b0, 1'b0, 1'b0, 32'h0, v); check("R1 low", v, 32'h0);
    step(1'b0, 1'b0, 1'b1, 32'h0, v); check("R1 high", v, 32'h0);
  endtask

  task automatic t_clear_read();
    logic [31:0] a, b;
    wr(1'b0, 32'h0); rd(1'b0, a); rd(1'b0, b); idle(1);
    check("R4 first read", a, 32'h0);
    check("R3 second read", b, 32'h1);
  endtask

  task automatic t_gaps();
    logic [31:0] a;
    logic [31:0] unused_rd;
    wr(1'b0, 32'h0);
    step(1'b1, 1'b0, 1'b0, 32'h0, unused_rd);
    idle(5);
    step(1'b1, 1'b0, 1'b0, 32'h0, unused_rd);
    step(1'b1, 1'b0, 1'b0, 32'h0, unused_rd);
    rd(1'b0, a); idle(1);
    check("R2 count per retire", a, 32'h3);
  endtask

  task automatic t_lo_carry();
    logic [31:0] a, b, c;
    wr(1'b0, 32'h0); wr(1'b1, 32'h0);
    for (int i = 0; i < 5; i++) wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b1, a); rd(1'b1, b); rd(1'b0, c); idle(1);
    check("R5 high after writes", a, 32'h4);
    check("R5 high after carry", b, 32'h5);
    check("R5 low after wrap", c, 32'h1);
  endtask

  task automatic t_wrap();
    logic [31:0] a, b, c;
    wr(1'b0, 32'h0); wr(1'b1, 32'h0);
    wr(1'b0, 32'hFFFF_FFFE); wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, a); rd(1'b1, b); rd(1'b0, c); idle(1);
    check("R6 high written, low counted", a, 32'hFFFF_FFFF);
    check("R7 high wrapped", b, 32'h0);
    check("R7 low wrapped", c, 32'h1);
  endtask

  task automatic t_hi_drops_carry();
    logic [31:0] a, b;
    wr(1'b0, 32'hFFFF_FFFF); wr(1'b1, 32'h7);
    rd(1'b1, a); rd(1'b0, b); idle(1);
    check("R6 carry discarded", a, 32'h7);
    check("R6 low still wrapped", b, 32'h1);
  endtask

  task automatic t_inhibit();
    logic [31:0] a, b, c;
    countinhibit_i = 32'h4;
    wr(1'b0, 32'h0); rd(1'b0, a); rd(1'b0, b);
    wr(1'b1, 32'h9); rd(1'b1, c); idle(1);
    check("R8 frozen read 1", a, 32'h0);
    check("R8 frozen read 2", b, 32'h0);
    check("R8 write under inhibit", c, 32'h9);
    countinhibit_i = 32'hFFFF_FFFB;
    wr(1'b0, 32'h0); rd(1'b0, a); rd(1'b0, b); idle(1);
    check("R9 other bits read 1", a, 32'h0);
    check("R9 other bits read 2", b, 32'h1);
    countinhibit_i = 32'h0;
  endtask

  task automatic t_no_retire_write();
    logic [31:0] a, b;
    logic [31:0] unused_rd;
    wr(1'b0, 32'h0); wr(1'b1, 32'h3);
    step(1'b0, 1'b1, 1'b0, 32'h55, unused_rd);
    step(1'b0, 1'b1, 1'b1, 32'hAA, unused_rd);
    rd(1'b0, a); rd(1'b1, b); idle(1);
    check("R10 low unaffected", a, 32'h1);
    check("R10 high unaffected", b, 32'h3);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_clear_read();
    t_gaps();
    t_lo_carry();
    t_wrap();
    t_hi_drops_carry();
    t_inhibit();
    t_no_retire_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule